// File: doc/BRIEF.md
# Modulator Output Line Formatter

This block sits between a one-bit delta-sigma modulator and the two-wire link to a receiver. It takes each modulator bit, together with a strobe that marks where a bit starts, and puts it on a data line and a clock line. The format depends on a two-pin mode selector. Three modes run from an internal oscillator, which the block receives as a one-cycle tick in its own clock domain. The fourth mode turns the clock pin around and takes its timing from an external clock input. The selected time base is called the bit clock below. Each modulator bit lasts two bit-clock ticks in every mode.

The block has a free-running system clock `clk`. All outputs are registered and change one `clk` cycle after the tick that caused the change. A mode change is taken up only where a new bit starts. When it is taken up, the internal divider starts again from phase zero, so the new output clock starts in a known phase. The block also raises a request to run the on-chip oscillator, and an enable that tells the pad whether to drive the clock pin.

Top module: `dsm_link_fmt`

## Requirements
- R1: The mode is `mode_sel` = {hi,lo}. 00 gives a half-rate clock line with raw data. 01 gives a quarter-rate clock line with raw data. 10 gives Manchester data on one wire. 11 takes an external clock with raw data.
- R2: In modes 00, 01 and 10 the bit clock advances on `osc_tick`. In mode 11 it advances only on a rising edge of `ext_clk`, and `osc_tick` pulses have no effect on any output.
- R3: In mode 00, `ser_clk` is low during the first tick of each bit and high during the second, so it rises mid-bit. `ser_dat` equals the current bit and `ser_clk_oe` is high.
- R4: In mode 01, `ser_clk` runs at a quarter of the bit clock. It is low on tick 0, high on ticks 1 and 2, and low on tick 3 of each four-tick period. It rises in the middle of every even bit and falls in the middle of every odd bit, and `ser_dat` equals the current bit.
- R5: In mode 10, `ser_dat` sends a 1 as high then low and a 0 as low then high, each half lasting one tick. `ser_clk` is driven low with `ser_clk_oe` high.
- R6: In mode 11, `ser_clk_oe` and `ser_clk` are low. `ser_dat` equals the current bit and changes after a rising `ext_clk` edge.
- R7: `osc_en` is high whenever the effective mode is 00, 01 or 10, and low in mode 11. Before the first bit this uses the pins directly.
- R8: After reset, `ser_clk`, `ser_clk_oe` and `ser_dat` stay low until the first tick that carries `mod_vld`. A tick without `mod_vld` never loads `mod_bit`.
- R9: A new `mode_sel` value takes effect only on a tick with `mod_vld` high. When it differs from the current mode, the divider phase restarts at tick 0.
- R10: `rst_n` low forces all outputs low at once, without waiting for a clock edge. Release takes effect after two `clk` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Mode pins {hi,lo} |
| osc_tick | input | 1 | One-cycle tick from the internal oscillator |
| ext_clk | input | 1 | External clock level, in the `clk` domain |
| mod_bit | input | 1 | Modulator output bit |
| mod_vld | input | 1 | Marks the tick that starts a new bit |
| ser_clk | output | 1 | Clock line value |
| ser_clk_oe | output | 1 | Drive enable for the clock pin |
| ser_dat | output | 1 | Data line |
| osc_en | output | 1 | Request to run the internal oscillator |

## Verification
The bench goes through every mode in turn and changes the mode pins in the middle of a bit. A design that applied the pins at once would show the new clock pattern one tick early. It also sends ticks without a strobe while `mod_bit` differs from the current bit; a design that loaded the bit on every tick would flip the data line mid-bit. In external-clock mode the bench pulses the oscillator tick, which must not move the Manchester or clock phase or the data. It also checks that the divider starts again at phase zero after a mode switch, because a stale phase shows up as an inverted quarter-rate clock or Manchester halves in the wrong order.

// File: rtl/dsmf_pkg.sv
package dsmf_pkg;
  typedef enum logic [1:0] {
    MD_HALF = 2'b00,
    MD_QTR  = 2'b01,
    MD_MAN  = 2'b10,
    MD_EXT  = 2'b11
  } lmode_t;

  // divider phase width: two bits cover the quarter-rate line clock
  localparam int PH_W = 2;
endpackage

// File: rtl/dsmf_rst_sync.sv
module dsmf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nx;

  always_comb begin
    sync_nx = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sync_q <= '0;
    else         sync_q <= sync_nx;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/dsmf_clk_sel.sv
module dsmf_clk_sel
  import dsmf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  lmode_t src_mode,
  input  logic   osc_tick,
  input  logic   ext_clk,
  output logic   tick,
  output logic   osc_req
);
  logic ext_q;
  logic ext_nx;

  always_comb begin
    ext_nx  = ext_clk;
    osc_req = (src_mode != MD_EXT);
    tick    = osc_req ? osc_tick : (ext_clk & ~ext_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_nx;
  end
endmodule

// File: rtl/dsmf_seq.sv
module dsmf_seq
  import dsmf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            mod_vld,
  input  logic            mod_bit,
  input  lmode_t          mode_pin,
  output logic            started,
  output lmode_t          mode_q,
  output logic            cur_bit,
  output logic [PH_W-1:0] ph,
  output lmode_t          src_mode
);
  logic            started_nx;
  lmode_t          mode_nx;
  logic            bit_nx;
  logic [PH_W-1:0] ph_nx;
  logic            boundary;
  logic            restart;

  always_comb begin
    boundary   = tick & mod_vld;
    restart    = boundary & (~started | (mode_pin != mode_q));
    started_nx = started;
    mode_nx    = mode_q;
    bit_nx     = cur_bit;
    ph_nx      = ph;
    if (boundary) begin
      started_nx = 1'b1;
      mode_nx    = mode_pin;
      bit_nx     = mod_bit;
    end
    if (restart)              ph_nx = '0;
    else if (tick && started) ph_nx = ph + 1'b1;
    src_mode = started ? mode_q : mode_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      mode_q  <= MD_HALF;
      cur_bit <= 1'b0;
      ph      <= '0;
    end else begin
      started <= started_nx;
      mode_q  <= mode_nx;
      cur_bit <= bit_nx;
      ph      <= ph_nx;
    end
  end
endmodule

// File: rtl/dsmf_line.sv
module dsmf_line
  import dsmf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            started,
  input  lmode_t          mode_q,
  input  logic            cur_bit,
  input  logic [PH_W-1:0] ph,
  input  logic            osc_req,
  output logic            ser_clk,
  output logic            ser_clk_oe,
  output logic            ser_dat,
  output logic            osc_en
);
  logic clk_nx, oe_nx, dat_nx, osc_nx;
  logic half_clk, qtr_clk, man_dat;

  always_comb begin
    half_clk = ph[0];
    qtr_clk  = ph[1] ^ ph[0];
    man_dat  = cur_bit ^ ph[0];
    osc_nx   = osc_req;
    clk_nx   = 1'b0;
    oe_nx    = 1'b0;
    dat_nx   = 1'b0;
    if (started) begin
      unique case (mode_q)
        MD_HALF: begin clk_nx = half_clk; oe_nx = 1'b1; dat_nx = cur_bit; end
        MD_QTR:  begin clk_nx = qtr_clk;  oe_nx = 1'b1; dat_nx = cur_bit; end
        MD_MAN:  begin clk_nx = 1'b0;     oe_nx = 1'b1; dat_nx = man_dat; end
        MD_EXT:  begin clk_nx = 1'b0;     oe_nx = 1'b0; dat_nx = cur_bit; end
        default: begin clk_nx = 1'b0;     oe_nx = 1'b0; dat_nx = 1'b0;    end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_clk    <= 1'b0;
      ser_clk_oe <= 1'b0;
      ser_dat    <= 1'b0;
      osc_en     <= 1'b0;
    end else begin
      ser_clk    <= clk_nx;
      ser_clk_oe <= oe_nx;
      ser_dat    <= dat_nx;
      osc_en     <= osc_nx;
    end
  end
endmodule

// File: rtl/dsm_link_fmt.sv
module dsm_link_fmt
  import dsmf_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       osc_tick,
  input  logic       ext_clk,
  input  logic       mod_bit,
  input  logic       mod_vld,
  output logic       ser_clk,
  output logic       ser_clk_oe,
  output logic       ser_dat,
  output logic       osc_en
);
  logic            rst_s;
  logic            tick;
  logic            osc_req;
  logic            started;
  logic            cur_bit;
  logic [PH_W-1:0] ph;
  lmode_t          mode_q;
  lmode_t          src_mode;
  lmode_t          mode_pin;

  assign mode_pin = lmode_t'(mode_sel);

  dsmf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_an(rst_n), .rst_sn(rst_s)
  );

  dsmf_clk_sel u_sel (
    .clk(clk), .rst_n(rst_s), .src_mode(src_mode),
    .osc_tick(osc_tick), .ext_clk(ext_clk),
    .tick(tick), .osc_req(osc_req)
  );

  dsmf_seq u_seq (
    .clk(clk), .rst_n(rst_s), .tick(tick), .mod_vld(mod_vld),
    .mod_bit(mod_bit), .mode_pin(mode_pin), .started(started),
    .mode_q(mode_q), .cur_bit(cur_bit), .ph(ph), .src_mode(src_mode)
  );

  dsmf_line u_line (
    .clk(clk), .rst_n(rst_s), .started(started), .mode_q(mode_q),
    .cur_bit(cur_bit), .ph(ph), .osc_req(osc_req),
    .ser_clk(ser_clk), .ser_clk_oe(ser_clk_oe),
    .ser_dat(ser_dat), .osc_en(osc_en)
  );
endmodule

// File: rtl/dsm_link_fmt_chk.sv
module dsm_link_fmt_chk (
  input logic       clk,
  input logic       rst_s,
  input logic       tick,
  input logic       mod_vld,
  input logic [1:0] mode_sel,
  input logic       started,
  input logic [1:0] mode_q,
  input logic [1:0] ph,
  input logic       ser_clk,
  input logic       ser_clk_oe,
  input logic       ser_dat,
  input logic       osc_en
);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    !started |=> (!ser_dat && !ser_clk_oe && !ser_clk));

  a_r6_ext_release: assert property (@(posedge clk) disable iff (!rst_s)
    (started && mode_q == 2'b11) |=> (!ser_clk_oe && !ser_clk && !osc_en));

  a_r5_man_clk_low: assert property (@(posedge clk) disable iff (!rst_s)
    (started && mode_q == 2'b10) |=> (!ser_clk && ser_clk_oe && osc_en));

  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_s)
    !(tick && mod_vld) |=> $stable(mode_q));

  a_r9_phase_restart: assert property (@(posedge clk) disable iff (!rst_s)
    (tick && mod_vld && (!started || mode_sel != mode_q)) |=> (ph == 2'b00));
endmodule

bind dsm_link_fmt dsm_link_fmt_chk u_chk (
  .clk(clk), .rst_s(rst_s), .tick(tick), .mod_vld(mod_vld),
  .mode_sel(mode_sel), .started(started), .mode_q(mode_q), .ph(ph),
  .ser_clk(ser_clk), .ser_clk_oe(ser_clk_oe), .ser_dat(ser_dat),
  .osc_en(osc_en)
);

// File: tb/dsm_link_fmt_test.sv
module dsm_link_fmt_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;
  // {src(ext=1), mode[1:0], vld, bit, exp_clk, exp_oe, exp_dat, exp_osc}
  localparam logic [8:0] VEC [0:NVEC-1] = '{
    9'b0_00_0_1_0001, 9'b0_00_1_1_0111, 9'b0_00_0_0_1111, 9'b0_00_1_0_0101,
    9'b0_01_0_0_1101, 9'b0_01_1_1_0111, 9'b0_01_0_0_1111, 9'b0_01_1_0_1101,
    9'b0_01_0_0_0101, 9'b0_01_1_1_0111, 9'b0_10_0_0_1111, 9'b0_10_1_1_0111,
    9'b0_10_0_0_0101, 9'b0_10_1_0_0101, 9'b0_10_0_0_0111, 9'b0_10_1_1_0111,
    9'b0_11_0_0_0101, 9'b0_11_1_0_0000, 9'b1_11_0_0_0000, 9'b1_11_1_1_0010,
    9'b1_11_0_0_0010, 9'b0_11_1_0_0010, 9'b1_00_1_0_0101, 9'b0_00_0_1_1101
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       osc_tick = 1'b0;
  logic       ext_clk = 1'b0;
  logic       mod_bit = 1'b0;
  logic       mod_vld = 1'b0;
  logic       ser_clk, ser_clk_oe, ser_dat, osc_en;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsm_link_fmt uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .osc_tick(osc_tick),
    .ext_clk(ext_clk), .mod_bit(mod_bit), .mod_vld(mod_vld),
    .ser_clk(ser_clk), .ser_clk_oe(ser_clk_oe), .ser_dat(ser_dat),
    .osc_en(osc_en)
  );

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // one bit-clock tick, sampled once the output registers have settled
  task automatic step(input logic src, input logic [1:0] m,
                      input logic v, input logic b);
    @(negedge clk);
    mode_sel = m; mod_vld = v; mod_bit = b;
    if (src) ext_clk = 1'b1; else osc_tick = 1'b1;
    @(negedge clk);
    osc_tick = 1'b0; mod_vld = 1'b0;
    @(negedge clk);
    ext_clk = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] eff;
    string tag;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10", "ser_clk", ser_clk, 1'b0);
    chk("R10", "ser_clk_oe", ser_clk_oe, 1'b0);
    chk("R10", "ser_dat", ser_dat, 1'b0);
    chk("R10", "osc_en", osc_en, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7", "osc_en idle mode 00", osc_en, 1'b1);
    chk("R8", "ser_clk_oe idle", ser_clk_oe, 1'b0);

    eff = 2'b00;
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][8], VEC[i][7:6], VEC[i][5], VEC[i][4]);
      if (VEC[i][5]) eff = VEC[i][7:6];
      if (i == 0)                          tag = "R8";
      else if (i == 4 || i == 10 || i == 16) tag = "R9";
      else if (i == 21)                    tag = "R2";
      else if (i == 18 || i == 22)         tag = "R1";
      else                                 tag = req_of(eff);
      chk(tag, $sformatf("row %0d ser_clk", i), ser_clk, VEC[i][3]);
      chk(tag, $sformatf("row %0d ser_clk_oe", i), ser_clk_oe, VEC[i][2]);
      chk(tag, $sformatf("row %0d ser_dat", i), ser_dat, VEC[i][1]);
      chk("R7", $sformatf("row %0d osc_en", i), osc_en, VEC[i][0]);
    end

    // R10 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10", "async ser_clk_oe", ser_clk_oe, 1'b0);
    chk("R10", "async ser_clk", ser_clk, 1'b0);
    chk("R10", "async osc_en", osc_en, 1'b0);
    mode_sel = 2'b11;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7", "osc_en idle mode 11", osc_en, 1'b0);
    chk("R8", "ser_dat idle mode 11", ser_dat, 1'b0);
    // R2 oscillator tick ignored before start in mode 11
    step(1'b0, 2'b11, 1'b1, 1'b1);
    chk("R2", "osc tick in mode 11 ser_dat", ser_dat, 1'b0);
    // R6 first bit from external clock
    step(1'b1, 2'b11, 1'b1, 1'b1);
    chk("R6", "ext start ser_dat", ser_dat, 1'b1);
    chk("R6", "ext start ser_clk_oe", ser_clk_oe, 1'b0);
    chk("R6", "ext start ser_clk", ser_clk, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule